// File: doc/BRIEF.md
# Byte-Lane Steering Bus Adapter

This block sits between a processor-side request port and a memory or peripheral port that only deals in whole 32-bit words. The processor presents a byte address, an access size of one, two or four bytes, and data that is justified to one end of its 32-bit data bus. The adapter turns that into a word-aligned memory request. The request carries four byte-enable lines, one per 8-bit lane, and the write data placed on the lanes that the access covers.

When a read returns, the adapter takes the addressed bytes out of the full word and justifies them before handing them back. Bytes the access did not cover are cleared to zero. A build-time parameter selects the byte order. In little-endian builds, data is justified to the low end of the bus. In big-endian builds, it is justified to the high end.

Accesses whose size and address offset do not fit together are refused with a one-cycle error pulse, and nothing reaches the memory side. A separate unit is expected to split such accesses. Both sides use valid/ready handshakes, and only one transaction is in flight at a time.

Top module: `lane_steer_adapter`

## Requirements
- R1: Every memory request carries `memAddr` equal to the processor byte address with its two low bits forced to 00.
- R2: Size codes are 00 = one byte, 01 = two bytes and 10 = four bytes; code 11 is never legal. A two-byte access needs address bit 0 clear, a four-byte access needs address bits 1:0 equal to 00, and a byte access is legal at every offset.
- R3: An illegal access is accepted, and then `cpuMisalign` is high for exactly the one cycle after acceptance. No memory request and no processor response follow.
- R4: Lane L covers data bits 8L+7:8L. Little-endian builds serve byte offset k on lane k, and big-endian builds serve it on lane 3-k. `memByteEn` is set exactly for the lanes of the bytes being accessed.
- R5: On writes, the byte at address a+j comes from processor data bits 8j+7:8j in little-endian builds, and from bits 31-8j:24-8j in big-endian builds. It is placed on the lane given by R4.
- R6: On reads, the byte at address a+j is returned in the processor data position given in R5. All bits outside the access are zero.
- R7: Read lanes that the access did not request have no effect on the returned data, whatever the memory drives on them.
- R8: While `memReqValid` is high and `memReqReady` is low, the request stays asserted with its address, enables, data and direction unchanged.
- R9: A processor response stays valid with unchanged data until `cpuRspReady` is seen. A write response carries all-zero data.
- R10: `cpuReqReady` is low from the acceptance of a request until its response or error pulse has ended, so that only one transaction is ever outstanding.
- R11: `memWrite` follows the direction of the accepted access. The processor response appears in the cycle after `memRspValid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Adapter can accept a request |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuSize | input | 2 | Access size code (R2) |
| cpuWdata | input | 32 | Justified write data |
| cpuRspValid | output | 1 | Response valid |
| cpuRspReady | input | 1 | Processor takes the response |
| cpuRdata | output | 32 | Justified read data, zero for writes |
| cpuMisalign | output | 1 | One-cycle illegal-access pulse |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | Memory request direction |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memByteEn | output | 4 | Per-lane byte enables |
| memWdata | output | 32 | Lane-placed write data |
| memRspValid | input | 1 | Memory completion, with read data |
| memRdata | input | 32 | Full memory read word |

## Verification
The bench builds two copies side by side: one with `BIG_ENDIAN` at 0 and one with it at 1, both using the default 32-bit address. Both copies receive the same stimulus, so each access checks the lane mapping and justification rules of both byte orders. The mirrored enable patterns are checked for every size and offset, and so are left- and right-justified data and zero fill at each end of the bus. The memory returns fully random words, so stale lanes are always present. Random stalls on both handshakes exercise the hold rules.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMREQ,
    ST_MEMWAIT,
    ST_CPURSP,
    ST_FAULT
  } adp_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureRsp;
  } dp_strobe_t;

  function automatic logic [2:0] byteCount(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: byteCount = 3'd1;
      SZ_HALF: byteCount = 3'd2;
      SZ_WORD: byteCount = 3'd4;
      default: byteCount = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lane_steer_dpath.sv
module lane_steer_dpath
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              reqLegal,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int OFS_W = $clog2(LANES);

  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        cntQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] steered;
  logic [OFS_W-1:0]  offQ;

  // size/offset legality of the incoming request
  always_comb begin
    case (acc_size_e'(cpuSize))
      SZ_BYTE: reqLegal = 1'b1;
      SZ_HALF: reqLegal = ~cpuAddr[0];
      SZ_WORD: reqLegal = (cpuAddr[1:0] == 2'b00);
      default: reqLegal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      cntQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.captureReq) begin
      addrQ  <= cpuAddr;
      cntQ   <= byteCount(cpuSize);
      writeQ <= cpuWrite;
      wdataQ <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.captureRsp) begin
      rdataQ <= writeQ ? '0 : steered;
    end
  end

  assign offQ     = addrQ[OFS_W-1:0];
  assign memAddr  = {addrQ[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign memWrite = writeQ;
  assign cpuRdata = rdataQ;

  // write side: per memory lane, decide enable and pick the source byte
  for (genvar L = 0; L < LANES; L++) begin : g_wlane
    localparam logic [2:0] LANE_OFS = BIG_ENDIAN ? 3'(LANES - 1 - L) : 3'(L);
    logic [2:0]       rel;
    logic             hit;
    logic [OFS_W-1:0] slot;

    assign rel  = LANE_OFS - {1'b0, offQ};
    assign hit  = (LANE_OFS >= {1'b0, offQ}) && (rel < cntQ);
    assign slot = BIG_ENDIAN ? 2'(3'(LANES - 1) - rel) : rel[OFS_W-1:0];

    assign memByteEn[L]               = hit;
    assign memWdata[LANE_W*L +: LANE_W] = hit ? wdataQ[LANE_W*slot +: LANE_W] : '0;
  end

  // read side: per processor byte slot, fetch from the lane or zero-fill
  for (genvar P = 0; P < LANES; P++) begin : g_rslot
    localparam logic [OFS_W-1:0] REL = BIG_ENDIAN ? 2'(LANES - 1 - P) : 2'(P);
    logic             want;
    logic [OFS_W-1:0] lane;

    assign want = ({1'b0, REL} < cntQ);
    assign lane = BIG_ENDIAN ? 2'(2'(LANES - 1) - (offQ + REL)) : 2'(offQ + REL);
    assign steered[LANE_W*P +: LANE_W] = want ? memRdata[LANE_W*lane +: LANE_W] : '0;
  end

endmodule

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       reqLegal,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       cpuRspReady,
  output logic       cpuReqReady,
  output logic       memReqValid,
  output logic       cpuRspValid,
  output logic       cpuMisalign,
  output dp_strobe_t strobe
);

  adp_state_e stateQ, stateD;

  always_comb begin
    stateD            = stateQ;
    strobe.captureReq = 1'b0;
    strobe.captureRsp = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (cpuReqValid) begin
          if (reqLegal) begin
            strobe.captureReq = 1'b1;
            stateD            = ST_MEMREQ;
          end else begin
            stateD = ST_FAULT;
          end
        end
      end
      ST_MEMREQ:  if (memReqReady) stateD = ST_MEMWAIT;
      ST_MEMWAIT: begin
        if (memRspValid) begin
          strobe.captureRsp = 1'b1;
          stateD            = ST_CPURSP;
        end
      end
      ST_CPURSP:  if (cpuRspReady) stateD = ST_IDLE;
      ST_FAULT:   stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign cpuReqReady = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_MEMREQ);
  assign cpuRspValid = (stateQ == ST_CPURSP);
  assign cpuMisalign = (stateQ == ST_FAULT);

endmodule

// File: rtl/lane_steer_adapter.sv
module lane_steer_adapter
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  output logic              cpuRspValid,
  input  logic              cpuRspReady,
  output logic [31:0]       cpuRdata,
  output logic              cpuMisalign,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memByteEn,
  output logic [31:0]       memWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRdata
);

  dp_strobe_t strobe;
  logic       reqLegal;

  lane_steer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReqValid (cpuReqValid),
    .reqLegal    (reqLegal),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .cpuRspReady (cpuRspReady),
    .cpuReqReady (cpuReqReady),
    .memReqValid (memReqValid),
    .cpuRspValid (cpuRspValid),
    .cpuMisalign (cpuMisalign),
    .strobe      (strobe)
  );

  lane_steer_dpath #(
    .ADDR_W     (ADDR_W),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuWrite  (cpuWrite),
    .cpuAddr   (cpuAddr),
    .cpuSize   (cpuSize),
    .cpuWdata  (cpuWdata),
    .memRdata  (memRdata),
    .reqLegal  (reqLegal),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memByteEn (memByteEn),
    .memWdata  (memWdata),
    .cpuRdata  (cpuRdata)
  );

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReqValid,
  input logic              cpuReqReady,
  input logic              cpuRspValid,
  input logic              cpuRspReady,
  input logic [31:0]       cpuRdata,
  input logic              cpuMisalign,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memByteEn,
  input logic [31:0]       memWdata
);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[1:0] == 2'b00);

  p_enable_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
                     $countones(memByteEn) == 4));

  p_fault_follows_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuMisalign |-> $past(cpuReqValid && cpuReqReady));

  p_fault_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuMisalign |=> !cpuMisalign && !memReqValid && !cpuRspValid);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr) &&
      $stable(memByteEn) && $stable(memWdata) && $stable(memWrite));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid && !cpuRspReady |=> cpuRspValid && $stable(cpuRdata));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || cpuRspValid || cpuMisalign) |-> !cpuReqReady);

endmodule

bind lane_steer_adapter lane_steer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReqValid (cpuReqValid),
  .cpuReqReady (cpuReqReady),
  .cpuRspValid (cpuRspValid),
  .cpuRspReady (cpuRspReady),
  .cpuRdata    (cpuRdata),
  .cpuMisalign (cpuMisalign),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memWrite    (memWrite),
  .memAddr     (memAddr),
  .memByteEn   (memByteEn),
  .memWdata    (memWdata)
);

// File: tb/lane_steer_adapter_bench.sv
module lane_steer_adapter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReqValid = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [1:0]  cpuSize = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuRspReady = 1'b0;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRdata = '0;

  // little-endian copy (L) and big-endian copy (B)
  logic        reqRdyL, rspVldL, misL, memVldL, memWrL;
  logic [31:0] rdataL, memAddrL, memWdL;
  logic [3:0]  memEnL;
  logic        reqRdyB, rspVldB, misB, memVldB, memWrB;
  logic [31:0] rdataB, memAddrB, memWdB;
  logic [3:0]  memEnB;

  int unsigned compared = 0;
  int unsigned mismatched = 0;
  int unsigned cycles = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  lane_steer_adapter #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) u_lane_steer_adapter (
    .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(reqRdyL),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata),
    .cpuRspValid(rspVldL), .cpuRspReady(cpuRspReady), .cpuRdata(rdataL),
    .cpuMisalign(misL), .memReqValid(memVldL), .memReqReady(memReqReady),
    .memWrite(memWrL), .memAddr(memAddrL), .memByteEn(memEnL), .memWdata(memWdL),
    .memRspValid(memRspValid), .memRdata(memRdata));

  lane_steer_adapter #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) u_lane_steer_adapter_be (
    .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(reqRdyB),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata),
    .cpuRspValid(rspVldB), .cpuRspReady(cpuRspReady), .cpuRdata(rdataB),
    .cpuMisalign(misB), .memReqValid(memVldB), .memReqReady(memReqReady),
    .memWrite(memWrB), .memAddr(memAddrB), .memByteEn(memEnB), .memWdata(memWdB),
    .memRspValid(memRspValid), .memRdata(memRdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  function automatic bit legal(input logic [1:0] sz, input logic [1:0] a);
    if (sz == 2'b00) return 1'b1;
    if (sz == 2'b01) return a[0] == 1'b0;
    if (sz == 2'b10) return a == 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [63:0] lowMask(input int n);
    return (64'd1 << (8 * n)) - 64'd1;
  endfunction

  function automatic logic [63:0] highMask(input int n);
    return lowMask(n) << (32 - 8 * n);
  endfunction

  function automatic logic [3:0] expEn(input bit be, input logic [1:0] a, input int n);
    logic [3:0] m;
    m = 4'((1 << n) - 1);
    return be ? 4'(m << (4 - int'(a) - n)) : 4'(m << a);
  endfunction

  function automatic logic [31:0] expWd(input bit be, input logic [1:0] a, input int n,
                                        input logic [31:0] wd);
    logic [63:0] w;
    w = {32'd0, wd};
    return be ? 32'((w & highMask(n)) >> (8 * a)) : 32'((w & lowMask(n)) << (8 * a));
  endfunction

  function automatic logic [31:0] expRd(input bit be, input logic [1:0] a, input int n,
                                        input logic [31:0] rd);
    logic [63:0] r;
    r = {32'd0, rd};
    return be ? 32'((r << (8 * a)) & highMask(n)) : 32'((r >> (8 * a)) & lowMask(n));
  endfunction

  task automatic access(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] word,
                        input int reqStall, input int rspGap, input int rspStall);
    int n;
    n = nBytes(sz);
    @(negedge clk);
    check("R10 ready before request (LE)", 32'(reqRdyL), 32'd1);
    check("R10 ready before request (BE)", 32'(reqRdyB), 32'd1);
    cpuReqValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuSize = sz; cpuWdata = wd;
    @(negedge clk);
    cpuReqValid = 1'b0; cpuWdata = $urandom; cpuAddr = $urandom;
    if (!legal(sz, addr[1:0])) begin
      check("R3 misalign pulse (LE)", 32'(misL), 32'd1);
      check("R3 misalign pulse (BE)", 32'(misB), 32'd1);
      check("R3 no memory request", 32'({memVldL, memVldB}), 32'd0);
      check("R2 illegal combination refused", 32'({rspVldL, rspVldB}), 32'd0);
      @(negedge clk);
      check("R3 pulse is one cycle", 32'({misL, misB, memVldL, memVldB}), 32'd0);
      check("R10 ready after fault", 32'({reqRdyL, reqRdyB}), 32'd3);
      return;
    end
    check("R2 legal access issued", 32'({memVldL, memVldB, misL, misB}), 32'hC);
    check("R10 busy after accept", 32'({reqRdyL, reqRdyB}), 32'd0);
    for (int s = 0; s <= reqStall; s++) begin
      check("R1 word address (LE)", memAddrL, {addr[31:2], 2'b00});
      check("R1 word address (BE)", memAddrB, {addr[31:2], 2'b00});
      check("R4 enables (LE)", 32'(memEnL), 32'(expEn(1'b0, addr[1:0], n)));
      check("R4 enables (BE)", 32'(memEnB), 32'(expEn(1'b1, addr[1:0], n)));
      check("R11 direction", 32'({memWrL, memWrB}), wr ? 32'd3 : 32'd0);
      if (wr) begin
        check("R5 write lanes (LE)", memWdL, expWd(1'b0, addr[1:0], n, wd));
        check("R5 write lanes (BE)", memWdB, expWd(1'b1, addr[1:0], n, wd));
      end
      check("R8 request held", 32'({memVldL, memVldB}), 32'd3);
      if (s == reqStall) memReqReady = 1'b1;
      @(negedge clk);
    end
    memReqReady = 1'b0;
    check("R8 request dropped after ready", 32'({memVldL, memVldB}), 32'd0);
    for (int g = 0; g < rspGap; g++) begin
      @(negedge clk);
      check("R11 no response before completion", 32'({rspVldL, rspVldB}), 32'd0);
    end
    memRspValid = 1'b1; memRdata = word;
    @(negedge clk);
    memRspValid = 1'b0; memRdata = $urandom;
    for (int s = 0; s <= rspStall; s++) begin
      check("R11 response follows completion", 32'({rspVldL, rspVldB}), 32'd3);
      if (wr) begin
        check("R9 write response zero", rdataL | rdataB, 32'd0);
      end else begin
        check("R6 R7 read justify (LE)", rdataL, expRd(1'b0, addr[1:0], n, word));
        check("R6 R7 read justify (BE)", rdataB, expRd(1'b1, addr[1:0], n, word));
      end
      check("R10 busy during response", 32'({reqRdyL, reqRdyB}), 32'd0);
      if (s == rspStall) cpuRspReady = 1'b1;
      @(negedge clk);
    end
    cpuRspReady = 1'b0;
    check("R9 response ends after ready", 32'({rspVldL, rspVldB}), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1A2B3C4D);
    repeat (3) @(negedge clk);
    check("R10 reset idle ready", 32'({reqRdyL, reqRdyB}), 32'd3);
    check("R3 reset outputs quiet",
          32'({rspVldL, rspVldB, misL, misB, memVldL, memVldB}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed: every size/offset, both directions, no stalls then with stalls
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < 4; a++) begin
        access(1'b1, 32'h8000_1000 + 32'(a), 2'(sz), 32'h11223344, 32'hA1B2C3D4, 0, 0, 0);
        access(1'b0, 32'h0000_7F00 + 32'(a), 2'(sz), 32'h0, 32'hCAFEF00D, 1, 2, 1);
      end
    // directed: all-ones memory word so zero fill is visible on every unused lane
    access(1'b0, 32'hFFFF_FFFD, 2'b00, 32'h0, 32'hFFFF_FFFF, 0, 0, 0);
    access(1'b0, 32'h0000_0002, 2'b01, 32'h0, 32'hFFFF_FFFF, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ad;
      logic [1:0]  sz;
      ad = $urandom;
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin
        if (sz == 2'b10) ad[1:0] = 2'b00;
        if (sz == 2'b01) ad[0] = 1'b0;
      end
      access(1'($urandom), ad, sz, $urandom, $urandom,
             $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule